// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This block settles one conditional relative branch for each instruction issued to it. It is given the branch opcode, the signed 8-bit offset fetched after the opcode, and the program counter value that already points past that offset byte. It also receives the current negative, zero and carry status flags. From these it works out whether the branch is taken and what the next program counter is. It also reports how many cycles the branch costs on top of the base instruction time.

A taken branch always costs one added cycle. It costs a second added cycle when the target lands in a different 256-byte page from the counter it started from. An opcode that is not one of the six recognised branch codes raises an invalid flag and leaves the counter unchanged. All results are registered and appear one clock after a request is presented with its valid strobe.

Top module: `branch_unit`

## Requirements
- R1: Opcode 0xF0 is taken when the zero flag is 1, and opcode 0xD0 is taken when the zero flag is 0.
- R2: Opcode 0xB0 is taken when the carry flag is 1, and opcode 0x90 is taken when the carry flag is 0.
- R3: Opcode 0x30 is taken when the negative flag is 1, and opcode 0x10 is taken when the negative flag is 0.
- R4: For a taken branch, `next_pc` equals `pc_in` plus the sign-extended `disp` (bit 7 is the sign), modulo 2^16.
- R5: For a recognised branch that is not taken, `next_pc` equals `pc_in`, `taken` is 0 and `extra_cycles` is 0.
- R6: For a taken branch whose target has the same bits 15:8 as `pc_in`, `extra_cycles` is 1.
- R7: For a taken branch whose target differs from `pc_in` in bits 15:8, `extra_cycles` is 2. The value 3 never occurs.
- R8: Any opcode other than the six above sets `invalid` to 1, `taken` to 0, `extra_cycles` to 0, and sets `next_pc` to `pc_in`.
- R9: The outputs update on the clock edge that samples `in_valid` high. `out_valid` is high for exactly the cycle after each such edge. When `in_valid` is low, `out_valid` goes low and all other outputs keep their values.
- R10: While `rst` is high, every output is cleared to 0 on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 8 | Branch opcode |
| disp | input | 8 | Signed offset |
| pc_in | input | 16 | Counter after the offset byte |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| out_valid | output | 1 | Result strobe |
| next_pc | output | 16 | Resolved next counter |
| taken | output | 1 | Branch taken |
| invalid | output | 1 | Opcode not a branch |
| extra_cycles | output | 2 | Added cycles: 0, 1 or 2 |

## Verification
The taken-branch charge and the page-crossing charge can both apply to the same request, and their sum must come out as 2. The bench provokes this in several ways: with negative offsets from counters near the start of a page, with positive offsets from counters near the end of a page, and with the wrap from 0xFFxx into 0x00xx. It also runs random offsets on random counters. Each registered result is compared with a bench model, which also confirms that a page crossing is never charged when the branch is not taken.

// File: rtl/branch_unit_pkg.sv
package branch_unit_pkg;
  localparam logic [7:0] OP_ZSET = 8'hF0;
  localparam logic [7:0] OP_ZCLR = 8'hD0;
  localparam logic [7:0] OP_CSET = 8'hB0;
  localparam logic [7:0] OP_CCLR = 8'h90;
  localparam logic [7:0] OP_NSET = 8'h30;
  localparam logic [7:0] OP_NCLR = 8'h10;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_Z    = 2'd1,
    SEL_C    = 2'd2,
    SEL_N    = 2'd3
  } flag_sel_t;

  typedef struct packed {
    logic      known;
    flag_sel_t sel;
    logic      want;
  } decode_t;
endpackage

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import branch_unit_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       flag_n,
  input  logic       flag_z,
  input  logic       flag_c,
  output logic       known,
  output logic       taken
);
  decode_t dec;
  logic    picked;

  always_comb begin
    dec = '{known: 1'b0, sel: SEL_NONE, want: 1'b0};
    case (opcode)
      OP_ZSET: dec = '{known: 1'b1, sel: SEL_Z, want: 1'b1};
      OP_ZCLR: dec = '{known: 1'b1, sel: SEL_Z, want: 1'b0};
      OP_CSET: dec = '{known: 1'b1, sel: SEL_C, want: 1'b1};
      OP_CCLR: dec = '{known: 1'b1, sel: SEL_C, want: 1'b0};
      OP_NSET: dec = '{known: 1'b1, sel: SEL_N, want: 1'b1};
      OP_NCLR: dec = '{known: 1'b1, sel: SEL_N, want: 1'b0};
      default: ;
    endcase
  end

  always_comb begin
    case (dec.sel)
      SEL_Z:   picked = flag_z;
      SEL_C:   picked = flag_c;
      SEL_N:   picked = flag_n;
      default: picked = 1'b0;
    endcase
  end

  assign known = dec.known;
  assign taken = dec.known && (picked == dec.want);
endmodule

// File: rtl/branch_target_calc.sv
module branch_target_calc #(
  parameter int PC_W      = 16,
  parameter int DISP_W    = 8,
  parameter int PAGE_BITS = 8
) (
  input  logic [PC_W-1:0]   pc_in,
  input  logic [DISP_W-1:0] disp,
  output logic [PC_W-1:0]   target,
  output logic              page_cross
);
  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    end else begin : g_noext
      assign disp_ext = disp[PC_W-1:0];
    end
  endgenerate

  assign target     = pc_in + disp_ext;
  assign page_cross = target[PC_W-1:PAGE_BITS] != pc_in[PC_W-1:PAGE_BITS];
endmodule

// File: rtl/branch_cost.sv
module branch_cost (
  input  logic       taken,
  input  logic       page_cross,
  output logic [1:0] extra
);
  always_comb begin
    if (!taken)          extra = 2'd0;
    else if (page_cross) extra = 2'd2;
    else                 extra = 2'd1;
  end
endmodule

// File: rtl/branch_unit.sv
module branch_unit #(
  parameter int PC_W      = 16,
  parameter int DISP_W    = 8,
  parameter int PAGE_BITS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [DISP_W-1:0] disp,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_c,
  output logic              out_valid,
  output logic [PC_W-1:0]   next_pc,
  output logic              taken,
  output logic              invalid,
  output logic [1:0]        extra_cycles
);
  logic            c_known;
  logic            c_taken;
  logic [PC_W-1:0] c_target;
  logic            c_cross;
  logic [1:0]      c_extra;

  branch_cond_eval i_cond (
    .opcode (opcode),
    .flag_n (flag_n),
    .flag_z (flag_z),
    .flag_c (flag_c),
    .known  (c_known),
    .taken  (c_taken)
  );

  branch_target_calc #(
    .PC_W      (PC_W),
    .DISP_W    (DISP_W),
    .PAGE_BITS (PAGE_BITS)
  ) i_target (
    .pc_in      (pc_in),
    .disp       (disp),
    .target     (c_target),
    .page_cross (c_cross)
  );

  branch_cost i_cost (
    .taken      (c_taken),
    .page_cross (c_cross),
    .extra      (c_extra)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      next_pc      <= '0;
      taken        <= 1'b0;
      invalid      <= 1'b0;
      extra_cycles <= 2'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        next_pc      <= c_taken ? c_target : pc_in;
        taken        <= c_taken;
        invalid      <= !c_known;
        extra_cycles <= c_extra;
      end
    end
  end
endmodule

// File: rtl/branch_unit_checker.sv
module branch_unit_checker #(
  parameter int PC_W      = 16,
  parameter int PAGE_BITS = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [PC_W-1:0] pc_in,
  input logic            out_valid,
  input logic [PC_W-1:0] next_pc,
  input logic            taken,
  input logic            invalid,
  input logic [1:0]      extra_cycles
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R9
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R9
  AST_IDLE_HOLD_PC: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(next_pc)); // R9
  AST_COST_RANGE: assert property (@(posedge clk) disable iff (rst)
    extra_cycles != 2'd3); // R7
  AST_TAKEN_CHARGED: assert property (@(posedge clk) disable iff (rst)
    out_valid && taken |-> extra_cycles != 2'd0); // R6
  AST_NOT_TAKEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !taken |-> next_pc == $past(pc_in) && extra_cycles == 2'd0); // R5
  AST_SAME_PAGE_ONE: assert property (@(posedge clk) disable iff (rst)
    out_valid && taken && next_pc[PC_W-1:PAGE_BITS] == $past(pc_in[PC_W-1:PAGE_BITS])
      |-> extra_cycles == 2'd1); // R6
  AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (rst)
    out_valid && invalid |-> !taken); // R8
endmodule

bind branch_unit branch_unit_checker #(.PC_W(PC_W), .PAGE_BITS(PAGE_BITS)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .pc_in        (pc_in),
  .out_valid    (out_valid),
  .next_pc      (next_pc),
  .taken        (taken),
  .invalid      (invalid),
  .extra_cycles (extra_cycles)
);

// File: tb/test_branch_unit.sv
module test_branch_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  disp = 8'h00;
  logic [15:0] pc_in = 16'h0000;
  logic        flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0;
  logic        out_valid, taken, invalid;
  logic [15:0] next_pc;
  logic [1:0]  extra_cycles;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_unit i_branch_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .disp(disp),
    .pc_in(pc_in), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .out_valid(out_valid), .next_pc(next_pc), .taken(taken),
    .invalid(invalid), .extra_cycles(extra_cycles)
  );

  function automatic bit m_known(input logic [7:0] op);
    return op inside {8'hF0, 8'hD0, 8'hB0, 8'h90, 8'h30, 8'h10};
  endfunction

  function automatic bit m_taken(input logic [7:0] op, input bit n, input bit z, input bit c);
    case (op)
      8'hF0: return z;
      8'hD0: return !z;
      8'hB0: return c;
      8'h90: return !c;
      8'h30: return n;
      8'h10: return !n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] m_target(input logic [15:0] pc, input logic [7:0] d);
    return pc + {{8{d[7]}}, d};
  endfunction

  function automatic string m_tag(input logic [7:0] op);
    case (op)
      8'hF0, 8'hD0: return "R1";
      8'hB0, 8'h90: return "R2";
      8'h30, 8'h10: return "R3";
      default:      return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] op, input logic [7:0] d, input logic [15:0] pc,
                     input bit n, input bit z, input bit c);
    bit          t;
    logic [15:0] tg;
    logic [1:0]  ex;
    t  = m_taken(op, n, z, c);
    tg = m_target(pc, d);
    ex = !t ? 2'd0 : ((tg[15:8] != pc[15:8]) ? 2'd2 : 2'd1);
    @(negedge clk);
    opcode = op; disp = d; pc_in = pc; flag_n = n; flag_z = z; flag_c = c;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", "out_valid", 32'(out_valid), 32'd1);
    check(m_tag(op), "taken", 32'(taken), 32'(t));
    check("R8", "invalid", 32'(invalid), 32'(!m_known(op)));
    check(t ? "R4" : "R5", "next_pc", 32'(next_pc), 32'(t ? tg : pc));
    check(!t ? "R5" : (ex == 2'd2 ? "R7" : "R6"), "extra", 32'(extra_cycles), 32'(ex));
  endtask

  initial begin
    int seed_v;
    logic [15:0] held;
    seed_v = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    check("R10", "reset out_valid", 32'(out_valid), 0);
    check("R10", "reset next_pc", 32'(next_pc), 0);
    check("R10", "reset extra", 32'(extra_cycles), 0);
    rst = 1'b0;

    // R1 R2 R3 both polarities, taken and not taken
    run(8'hF0, 8'h04, 16'h1210, 0, 1, 0);
    run(8'hF0, 8'h04, 16'h1210, 0, 0, 0);
    run(8'hD0, 8'h04, 16'h1210, 0, 0, 0);
    run(8'hB0, 8'h10, 16'h2000, 0, 0, 1);
    run(8'h90, 8'h10, 16'h2000, 0, 0, 1);
    run(8'h30, 8'hF0, 16'h3080, 1, 0, 0);
    run(8'h10, 8'hF0, 16'h3080, 1, 0, 0);
    // R7 crossings: backward, forward, wrap; R6 page edge stays
    run(8'hF0, 8'hFE, 16'h4001, 0, 1, 0);
    run(8'hF0, 8'h7F, 16'h40F0, 0, 1, 0);
    run(8'hD0, 8'h20, 16'hFFF0, 0, 0, 0);
    run(8'hD0, 8'h80, 16'h0010, 0, 0, 0);
    run(8'hD0, 8'hFF, 16'h50FF, 0, 0, 0);
    run(8'hD0, 8'h00, 16'h5000, 0, 0, 0);
    // R8 non-branch opcodes with all flags set
    run(8'hEA, 8'h40, 16'h6000, 1, 1, 1);
    run(8'hF1, 8'h40, 16'h6000, 1, 1, 1);

    // R9 idle: outputs hold, out_valid low
    held = next_pc;
    @(negedge clk);
    pc_in = 16'hABCD; opcode = 8'hF0; flag_z = 1'b1;
    @(negedge clk);
    check("R9", "idle out_valid", 32'(out_valid), 0);
    check("R9", "idle hold next_pc", 32'(next_pc), 32'(held));

    for (int i = 0; i < 400; i++) begin
      logic [7:0] op;
      int k;
      k = int'($urandom_range(0, 7));
      case (k)
        0: op = 8'hF0; 1: op = 8'hD0; 2: op = 8'hB0; 3: op = 8'h90;
        4: op = 8'h30; 5: op = 8'h10;
        default: op = 8'($urandom);
      endcase
      run(op, 8'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule